// File: doc/BRIEF.md
# Triple-Channel Watchdog Timer Controller

This block holds three independent watchdog channels behind a small memory-mapped register port. Each channel has a 16-bit down-counter and a limit register. A shared prescaler divides the system clock down to a tick of one tenth of a second, and a running counter decrements once per tick. Software starts a channel by writing its limit register. It keeps the channel alive by reading the channel's counter register: the read returns the current count and reloads the counter from the limit.

When a channel's count reaches zero it stops and latches an expired flag. Each channel takes its own action on expiry. Channel 0 drives a level interrupt. Channel 1 emits a fixed-length pulse on a processor-reset output. Channel 2 emits the same pulse on a whole-board reset output. A shared three-bit mask register can suppress each action. A masked channel still counts down and still reports expiry in its status register.

The register port takes a single-cycle request and returns read data one clock later with a valid strobe. The port has no back-pressure: every request is accepted in the cycle it is presented, so no ready signal exists. A size input selects halfword or byte access.

Top module: `wdt3_ctrl`

## Requirements
- R1: After reset, the counter and limit registers of every channel read 1, every status register reads 0, the mask register reads 0, and `irq_o`, `cpu_rst_o` and `board_rst_o` are low.
- R2: While a channel is running, its counter decrements by one once every `TICK_DIV` clocks. The shared tick fires on the `TICK_DIV`-th clock edge after reset and repeats every `TICK_DIV` clocks after that.
- R3: A write to a channel's limit register (offset 0x4 in the channel's window) loads both the limit and the counter with the written value, sets the running bit and clears the expired bit. A write to a channel that is already running restarts it with the new value.
- R4: A read of a channel's counter register (offset 0x0) returns the count held before the edge and reloads the counter from the limit. The reload does not start a stopped channel. Reads of the limit and status registers change nothing. A reload that falls in a tick cycle takes precedence over the decrement.
- R5: On a tick where a running channel's count is 0 or 1, the count becomes 0, the running bit clears and the expired bit sets. The expired bit stays set until the next limit write. Writing a limit of 0 therefore expires the channel on the next tick.
- R6: A status read returns bit 0 = running and bit 1 = expired. All other bits read 0.
- R7: `irq_o` is a level signal that is high exactly while channel 0 is expired and mask bit 0 is clear.
- R8: An expiry of channel 1 drives `cpu_rst_o` high for exactly `PULSE_LEN` clocks, starting the clock after the expiry edge. An expiry of channel 2 does the same on `board_rst_o`. Each pulse is suppressed when mask bit 1 (or bit 2, respectively) is set at the moment of expiry.
- R9: Setting a mask bit does not stop its channel. The channel keeps counting and its status still shows expired.
- R10: Register addressing and access size work as follows:
  - Channel *i* occupies addresses 16·*i* to 16·*i*+15, and the mask register is at 0x30.
  - Read data appears on `bus_rdata`, with `bus_rvalid` high, one clock after a read request.
  - A byte read returns the low byte of the register, zero-extended.
  - A byte write stores the low data byte, zero-extended.
  - Unmapped addresses read 0.
  - Writes to counter and status registers are ignored.
- R11: A limit write that falls in a tick cycle takes precedence over the decrement and over expiry of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, held until the next read |
| bus_rvalid | output | 1 | High for one clock when `bus_rdata` carries new read data |
| irq_o | output | 1 | Channel 0 expiry interrupt, level |
| cpu_rst_o | output | 1 | Channel 1 processor-reset pulse |
| board_rst_o | output | 1 | Channel 2 board-reset pulse |

## Verification
The functions that can land in the same cycle are the prescaler tick and a software access to a channel: a keep-alive counter read, or a limit write. The bench tracks the prescaler phase in its reference model and issues both kinds of access exactly on the clock where the tick fires. The model gives the access priority over the decrement and over expiry. Every output, read data included, is compared against the model on every clock, so any wrong priority appears as a count that differs on a later read, or as a reset pulse or interrupt that arrives on the wrong clock.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;
  localparam int NUM_CH   = 3;
  localparam int CNT_W    = 16;
  localparam int MASK_W   = NUM_CH;

  // register selected inside a channel window (address bits 3:0)
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } ch_sel_e;

  localparam logic [3:0] OFS_COUNT  = 4'h0;
  localparam logic [3:0] OFS_LIMIT  = 4'h4;
  localparam logic [3:0] OFS_STATUS = 4'h8;
  localparam logic [5:0] ADDR_MASK  = 6'h30;

  function automatic ch_sel_e decode_ofs(input logic [3:0] ofs);
    case (ofs)
      OFS_COUNT:  return SEL_COUNT;
      OFS_LIMIT:  return SEL_LIMIT;
      OFS_STATUS: return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wdt3_prescale.sv
module wdt3_prescale #(
  parameter int DIV = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      assign tick = (phase_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdt3_channel.sv
module wdt3_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          reload,
  output logic [CW-1:0] count,
  output logic [CW-1:0] limit,
  output logic          running,
  output logic          expired,
  output logic          expire_evt
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic near_zero;
  assign near_zero  = (count[CW-1:1] == '0);
  // software access in the same cycle wins over the tick
  assign expire_evt = tick & running & ~load & ~reload & near_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= ONE;
      limit   <= ONE;
      running <= 1'b0;
      expired <= 1'b0;
    end else if (load) begin
      limit   <= load_val;
      count   <= load_val;
      running <= 1'b1;
      expired <= 1'b0;
    end else if (reload) begin
      count   <= limit;
    end else if (expire_evt) begin
      count   <= '0;
      running <= 1'b0;
      expired <= 1'b1;
    end else if (tick && running) begin
      count   <= count - ONE;
    end
  end
endmodule

// File: rtl/wdt3_pulse.sv
module wdt3_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (fire)            left_q <= LW'(LEN);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdt3_ctrl.sv
module wdt3_ctrl
  import wdt3_pkg::*;
#(
  parameter int TICK_DIV  = 5_000_000,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_half,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        board_rst_o
);
  logic              tick;
  logic [1:0]        win;
  ch_sel_e           sel;
  logic [CNT_W-1:0]  wr_val;
  logic [MASK_W-1:0] mask_q;
  logic              mask_wr;

  logic [NUM_CH-1:0] run_v, exp_v, evt_v, ld_v, rld_v;
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  logic [CNT_W-1:0]  lim_a [NUM_CH];
  logic [NUM_CH:1]   act_v;

  assign win     = bus_addr[5:4];
  assign sel     = decode_ofs(bus_addr[3:0]);
  assign wr_val  = bus_half ? bus_wdata : {8'h00, bus_wdata[7:0]};
  assign mask_wr = bus_req & bus_we & (bus_addr == ADDR_MASK);

  wdt3_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ld_v[c]  = bus_req & bus_we  & (win == 2'(c)) & (sel == SEL_LIMIT);
      assign rld_v[c] = bus_req & ~bus_we & (win == 2'(c)) & (sel == SEL_COUNT);

      wdt3_channel #(.CW(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(ld_v[c]), .load_val(wr_val), .reload(rld_v[c]),
        .count(cnt_a[c]), .limit(lim_a[c]),
        .running(run_v[c]), .expired(exp_v[c]), .expire_evt(evt_v[c])
      );
    end

    // channels above 0 act through a stretched reset pulse
    for (genvar k = 1; k < NUM_CH; k++) begin : g_act
      wdt3_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n),
        .fire(evt_v[k] & ~mask_q[k]),
        .pulse(act_v[k])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_val[MASK_W-1:0];
  end

  // read path
  logic [15:0] rd_word, rd_sized;
  always_comb begin
    rd_word = '0;
    if (bus_addr == ADDR_MASK) begin
      rd_word = {{(16-MASK_W){1'b0}}, mask_q};
    end else if (win < 2'(NUM_CH)) begin
      case (sel)
        SEL_COUNT:  rd_word = cnt_a[win];
        SEL_LIMIT:  rd_word = lim_a[win];
        SEL_STATUS: rd_word = {14'h0, exp_v[win], run_v[win]};
        default:    rd_word = '0;
      endcase
    end
    rd_sized = bus_half ? rd_word : {8'h00, rd_word[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req & ~bus_we;
      if (bus_req && !bus_we) bus_rdata <= rd_sized;
    end
  end

  assign irq_o       = exp_v[0] & ~mask_q[0];
  assign cpu_rst_o   = act_v[1];
  assign board_rst_o = act_v[2];
endmodule

// File: rtl/wdt3_ctrl_chk.sv
module wdt3_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_we,
  input logic [5:0] bus_addr,
  input logic       bus_rvalid,
  input logic       irq_o,
  input logic       cpu_rst_o,
  input logic       board_rst_o,
  input logic [2:0] run_v,
  input logic [2:0] exp_v,
  input logic [2:0] evt_v,
  input logic [2:0] mask_q
);
  logic lim0_wr;
  assign lim0_wr = bus_req & bus_we & (bus_addr == 6'h04);

  // R6: running and expired are never reported together
  p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_v & exp_v) == 3'b000);

  // R3: a limit write starts the channel
  p_write_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lim0_wr |=> (run_v[0] && !exp_v[0]));

  // R5: expiry is sticky until the next limit write
  p_exp_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_v[0] && !lim0_wr) |=> exp_v[0]);

  // R7: a set mask bit keeps the interrupt low
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[0] |-> !irq_o);

  // R8: a processor reset pulse only starts after an unmasked expiry
  p_cpu_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |-> $past(evt_v[1] && !mask_q[1]));

  // R8: the board reset pulse, likewise
  p_board_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst_o) |-> $past(evt_v[2] && !mask_q[2]));

  // R10: read data is strobed one clock after a read request
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
endmodule

bind wdt3_ctrl wdt3_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .irq_o(irq_o),
  .cpu_rst_o(cpu_rst_o), .board_rst_o(board_rst_o),
  .run_v(run_v), .exp_v(exp_v), .evt_v(evt_v), .mask_q(mask_q)
);

// File: tb/wdt3_ctrl_test.sv
`timescale 1ns/1ps
module wdt3_ctrl_test;
  localparam int DIV = 4;
  localparam int PLEN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_half = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, irq_o, cpu_rst_o, board_rst_o;

  always #2.5 clk = ~clk;

  wdt3_ctrl #(.TICK_DIV(DIV), .PULSE_LEN(PLEN)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq_o),
    .cpu_rst_o(cpu_rst_o), .board_rst_o(board_rst_o)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model
  int m_pc;
  int m_cnt[3], m_lim[3], m_run[3], m_exp[3], m_pl[3];
  int m_mask, m_rdata, m_rvalid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_mask = 0; m_rdata = 0; m_rvalid = 0;
      for (int c = 0; c < 3; c++) begin
        m_cnt[c] = 1; m_lim[c] = 1; m_run[c] = 0; m_exp[c] = 0; m_pl[c] = 0;
      end
    end else begin
      bit tk;
      int a, w, o, v, rv;
      bit evt[3];
      tk = (m_pc == DIV - 1);
      m_pc = tk ? 0 : m_pc + 1;
      a = bus_addr; w = a / 16; o = a % 16;
      v = bus_half ? bus_wdata : (bus_wdata & 8'hFF);
      rv = 0;
      if (a == 6'h30) rv = m_mask;
      else if (w < 3) begin
        if (o == 0) rv = m_cnt[w];
        else if (o == 4) rv = m_lim[w];
        else if (o == 8) rv = m_exp[w] * 2 + m_run[w];
      end
      if (!bus_half) rv = rv & 8'hFF;
      for (int c = 0; c < 3; c++) begin
        evt[c] = 0;
        if (bus_req && bus_we && w == c && o == 4) begin
          m_lim[c] = v; m_cnt[c] = v; m_run[c] = 1; m_exp[c] = 0;
        end else if (bus_req && !bus_we && w == c && o == 0) begin
          m_cnt[c] = m_lim[c];
        end else if (tk && m_run[c] != 0) begin
          if (m_cnt[c] <= 1) begin
            m_cnt[c] = 0; m_run[c] = 0; m_exp[c] = 1; evt[c] = 1;
          end else m_cnt[c] = m_cnt[c] - 1;
        end
      end
      for (int k = 1; k < 3; k++) begin
        if (evt[k] && ((m_mask >> k) & 1) == 0) m_pl[k] = PLEN;
        else if (m_pl[k] > 0) m_pl[k] = m_pl[k] - 1;
      end
      if (bus_req && bus_we && a == 6'h30) m_mask = v & 7;
      m_rvalid = (bus_req && !bus_we) ? 1 : 0;
      if (bus_req && !bus_we) m_rdata = rv;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  int cpu_hi = 0, brd_hi = 0;

  // compare against the model on every clock
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(irq_o == ((m_exp[0] != 0) && (m_mask & 1) == 0), cur_req, "irq",
          irq_o, (m_exp[0] != 0) && (m_mask & 1) == 0);
      chk(cpu_rst_o == (m_pl[1] > 0), cur_req, "cpu_rst", cpu_rst_o, m_pl[1] > 0);
      chk(board_rst_o == (m_pl[2] > 0), cur_req, "board_rst", board_rst_o, m_pl[2] > 0);
      chk(bus_rvalid == m_rvalid[0], cur_req, "rvalid", bus_rvalid, m_rvalid);
      chk(bus_rdata == 16'(m_rdata), cur_req, "rdata", bus_rdata, m_rdata);
      if (cpu_rst_o) cpu_hi++;
      if (board_rst_o) brd_hi++;
    end
    if (cycles > 40000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic op(input bit we, input bit half, input logic [5:0] a,
                    input logic [15:0] d);
    bus_req = 1; bus_we = we; bus_half = half; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_half = 1;
  endtask

  task automatic rd(input bit half, input logic [5:0] a, input int exp,
                    input string tag);
    op(0, half, a, 16'h0);
    chk(bus_rdata == 16'(exp), tag, "read", bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_slot();
    while (m_pc != DIV - 1) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values
    cur_req = "R1";
    rd(1, 6'h00, 1, "R1"); rd(1, 6'h04, 1, "R1"); rd(1, 6'h08, 0, "R1");
    rd(1, 6'h14, 1, "R1"); rd(1, 6'h24, 1, "R1"); rd(1, 6'h30, 0, "R1");
    chk(!irq_o && !cpu_rst_o && !board_rst_o, "R1", "outputs", irq_o, 0);

    // R2/R3: start channel 0 and watch it count
    cur_req = "R2";
    op(1, 1, 6'h04, 16'd5);
    idle(9);
    op(0, 1, 6'h08, 0);
    chk(bus_rdata == 16'h1, "R6", "status running", bus_rdata, 1);
    idle(25);
    // R5/R7: expired, interrupt high
    cur_req = "R5";
    chk(irq_o == 1, "R7", "irq after expiry", irq_o, 1);
    rd(1, 6'h08, 2, "R5");
    rd(1, 6'h00, 0, "R4");
    rd(1, 6'h08, 2, "R4");
    rd(1, 6'h00, 5, "R4");
    // R7: mask suppresses, unmask restores
    cur_req = "R7";
    op(1, 1, 6'h30, 16'h1);
    chk(irq_o == 0, "R7", "irq masked", irq_o, 0);
    op(1, 1, 6'h30, 16'h0);
    chk(irq_o == 1, "R7", "irq unmasked", irq_o, 1);
    // R3: restart clears expired
    cur_req = "R3";
    op(1, 1, 6'h04, 16'd40);
    chk(irq_o == 0, "R3", "irq after restart", irq_o, 0);

    // R8: kept alive, then allowed to expire
    cur_req = "R8";
    cpu_hi = 0;
    op(1, 1, 6'h14, 16'd3);
    for (int i = 0; i < 8; i++) begin
      idle(5);
      op(0, 1, 6'h10, 0);
    end
    chk(cpu_hi == 0, "R8", "no pulse while serviced", cpu_hi, 0);
    idle(25);
    chk(cpu_hi == PLEN, "R8", "cpu pulse length", cpu_hi, PLEN);

    // R9: masked channel 2 still expires, no board pulse
    cur_req = "R9";
    brd_hi = 0;
    op(1, 1, 6'h30, 16'h4);
    op(1, 1, 6'h24, 16'd2);
    idle(16);
    chk(brd_hi == 0, "R8", "masked board pulse", brd_hi, 0);
    rd(1, 6'h28, 2, "R9");
    op(1, 1, 6'h30, 16'h0);
    op(1, 1, 6'h24, 16'd2);
    idle(16);
    chk(brd_hi == PLEN, "R8", "board pulse length", brd_hi, PLEN);

    // R4/R11: accesses on tick cycles
    cur_req = "R11";
    op(1, 1, 6'h04, 16'd8);
    idle(3);
    wait_slot(); op(0, 1, 6'h00, 0);
    wait_slot(); op(0, 1, 6'h00, 0);
    rd(1, 6'h00, 8, "R4");
    wait_slot(); op(1, 1, 6'h04, 16'd3);
    wait_slot(); op(1, 1, 6'h04, 16'd1);
    wait_slot(); op(1, 1, 6'h04, 16'd1);
    rd(1, 6'h08, 1, "R11");
    idle(6);
    rd(1, 6'h08, 2, "R5");

    // R5: limit zero expires on the next tick
    cur_req = "R5";
    op(1, 1, 6'h04, 16'd0);
    idle(5);
    rd(1, 6'h08, 2, "R5");

    // R10: byte access, ignored writes, unmapped reads
    cur_req = "R10";
    op(1, 1, 6'h14, 16'h1234);
    rd(0, 6'h14, 16'h34, "R10");
    op(1, 0, 6'h14, 16'hABCD);
    rd(1, 6'h14, 16'h00CD, "R10");
    op(1, 1, 6'h10, 16'h7777);
    op(1, 1, 6'h18, 16'h7777);
    rd(1, 6'h14, 16'h00CD, "R10");
    rd(1, 6'h34, 0, "R10");
    rd(1, 6'h3C, 0, "R10");
    rd(1, 6'h0C, 0, "R10");
    op(1, 1, 6'h30, 16'hFFFF);
    rd(1, 6'h30, 7, "R10");
    idle(10);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule